// File: doc/BRIEF.md
# Password-Gated Partitioned Memory Controller

This block guards a small flip-flop memory split into three secure partitions and one open scratchpad. Every secure partition carries a 64-bit identifier, a 64-bit password and a 256-bit secure data field, so each partition is 384 bits. The scratchpad is 512 bits and needs no credential. A host reaches the memory through a bit-serial session. `sess_en` frames the session, a bit slot is any cycle with `bit_vld` high, `bit_in` carries host bits, and `bit_out` with `out_act` carries device bits.

Each session begins with a command byte and an address byte. A secure command first returns the partition identifier. It then takes a 64-bit credential from the host and compares it one bit per slot. A proven identifier lets the host re-key the partition, which wipes it first. A proven password lets the host write or read secure data. When the credential does not match, the session does nothing more.

Top module: `keyvault_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every identifier, password, secure data bit and scratchpad bit to zero, returns to idle and holds `out_act` low.
- R2: A session opens on the cycle after `sess_en` is first sampled high. Only cycles with `bit_vld` high count as slots. Slot bits are LSB first: 8 command bits, then 8 address bits. Command bits [7:4] hold the opcode, bits [3:2] must be zero, and bits [1:0] select the partition.
- R3: Opcodes 1 (re-key), 2 (secure write) and 3 (secure read) on partitions 0 to 2 first drive the 64-bit identifier on `bit_out`, LSB first, with `out_act` high for exactly those 64 slots.
- R4: The next 64 slots take a credential. Re-key compares it with the identifier and the other two opcodes compare it with the password. A mismatch in any bit ends the transaction with no storage change, and `out_act` stays low for the rest of the session.
- R5: On a re-key match, the partition's identifier, password and secure data become zero. The following 64 slots supply the new identifier and the 64 after those supply the new password.
- R6: After a password match, a secure write stores slot bits from bit (address mod 32)*8 of the data field upward. It stops after bit 255, and later slots are ignored.
- R7: After a password match, a secure read drives data bits from (address mod 32)*8 through bit 255 with `out_act` high. After that `out_act` stays low.
- R8: When `sess_en` is sampled low, the block is idle and `out_act` is low on the next cycle. A new identifier or password that has not fully arrived is discarded. Data bits that were already written stay.
- R9: Opcode 4 writes and opcode 5 reads the scratchpad from bit (address mod 64)*8 through bit 511, with no credential phase.
- R10: An undefined opcode, nonzero reserved bits, or partition 3 with a secure opcode changes nothing and drives nothing for the whole session.
- R11: An operation on one partition leaves the other partitions and the scratchpad unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sess_en | input | 1 | Session frame, high while a transaction is open |
| bit_vld | input | 1 | Marks the current cycle as a bit slot |
| bit_in | input | 1 | Host bit for the current slot |
| bit_out | output | 1 | Device bit, meaningful while `out_act` is high |
| out_act | output | 1 | High in slots where the device drives a bit |

## Verification
The embedded assertions watch properties that hold on every cycle. A dropped session must silence the output on the next cycle. The mismatch flag must stay set once set. An erase must lead into the new-identifier phase. At most one storage write strobe may fire per cycle, none may fire for an absent partition, and the data pointer must stay inside its field.

The bench scenarios cover behaviour that only shows across whole sessions. They show that a wrong credential leaves storage untouched and that re-keying wipes old secure data. They also show that an aborted re-key leaves the credentials at zero, that address bits wrap and stop at the end of a field, and that a neighbouring partition keeps its contents.

// File: rtl/keyvault_pkg.sv
// Shared types for the partitioned key vault controller: the session state
// encoding and the opcode values carried in command bits [7:4].
package keyvault_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_IDOUT,
        S_CMP,
        S_NEWID,
        S_NEWPW,
        S_WR,
        S_RD,
        S_DONE
    } kv_state_e;

    localparam logic [3:0] OP_REKEY  = 4'h1;
    localparam logic [3:0] OP_SEC_WR = 4'h2;
    localparam logic [3:0] OP_SEC_RD = 4'h3;
    localparam logic [3:0] OP_SCR_WR = 4'h4;
    localparam logic [3:0] OP_SCR_RD = 4'h5;

    localparam int CMD_BITS = 16;

endpackage

// File: rtl/keyvault_cmp.sv
// Bit-serial credential comparator with a sticky mismatch flag.
// Assumes: one received bit and one stored reference bit per enabled cycle,
// and clr is held while no compare phase is running.
module keyvault_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic rx_bit,
    input  logic ref_bit,
    output logic mm_nx
);

    logic mm_q;

    // Mismatch including the bit arriving in this cycle.
    assign mm_nx = mm_q | (en & (rx_bit ^ ref_bit));

    // Sticky flag: cleared outside the compare phase, set by any differing bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mm_q <= 1'b0;
        end else if (en) begin
            mm_q <= mm_nx;
        end
    end

    // R4: one differing bit must keep the mismatch until the phase ends.
    assert_mismatch_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_q && !clr) |=> mm_q);

endmodule

// File: rtl/keyvault_store.sv
// Flip-flop storage: per-partition identifier, password and secure data,
// plus the open scratchpad. Provides bit-granular reads and writes.
// Assumes: the controller raises at most one write strobe per cycle and
// never targets a partition index of N_PART or above.
module keyvault_store #(
    parameter int N_PART  = 3,
    parameter int CRED_W  = 64,
    parameter int SD_BITS = 256,
    parameter int SC_BITS = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 part,
    input  logic [$clog2(CRED_W)-1:0]  fld_idx,
    input  logic [$clog2(SC_BITS)-1:0] dat_idx,
    input  logic                       erase,
    input  logic                       id_we,
    input  logic                       pw_we,
    input  logic                       sd_we,
    input  logic                       sc_we,
    input  logic                       wbit,
    input  logic [CRED_W-1:0]          cred_val,
    output logic                       id_bit,
    output logic                       pw_bit,
    output logic                       sd_bit,
    output logic                       sc_bit
);

    localparam int SD_IW = $clog2(SD_BITS);

    logic [N_PART-1:0][CRED_W-1:0]  id_v;
    logic [N_PART-1:0][CRED_W-1:0]  pw_v;
    logic [N_PART-1:0][SD_BITS-1:0] sd_v;
    logic [SC_BITS-1:0]             sc_q;
    logic [1:0]                     sel_c;
    logic [SD_IW-1:0]               sd_idx;

    assign sel_c  = (int'(part) < N_PART) ? part : 2'd0;
    assign sd_idx = dat_idx[SD_IW-1:0];

    for (genvar p = 0; p < N_PART; p++) begin : g_part
        logic [CRED_W-1:0]  id_r;
        logic [CRED_W-1:0]  pw_r;
        logic [SD_BITS-1:0] sd_r;

        // Per-partition fields: erase, credential commit and data bit writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_r <= '0;
                pw_r <= '0;
                sd_r <= '0;
            end else if (int'(part) == p) begin
                if (erase) begin
                    id_r <= '0;
                    pw_r <= '0;
                    sd_r <= '0;
                end
                if (id_we) id_r <= cred_val;
                if (pw_we) pw_r <= cred_val;
                if (sd_we) sd_r[sd_idx] <= wbit;
            end
        end

        assign id_v[p] = id_r;
        assign pw_v[p] = pw_r;
        assign sd_v[p] = sd_r;
    end

    // Scratchpad bit writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else if (sc_we) begin
            sc_q[dat_idx] <= wbit;
        end
    end

    assign id_bit = id_v[sel_c][fld_idx];
    assign pw_bit = pw_v[sel_c][fld_idx];
    assign sd_bit = sd_v[sel_c][sd_idx];
    assign sc_bit = sc_q[dat_idx];

    // R11: at most one kind of write per cycle.
    assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase, id_we, pw_we, sd_we, sc_we}));

    // R10: an absent partition is never written.
    assert_no_absent_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(part) >= N_PART) |-> !(erase || id_we || pw_we || sd_we));

endmodule

// File: rtl/keyvault_ctrl.sv
// Session controller for the partitioned key vault. Decodes the command and
// address bytes, returns the identifier, checks a credential bit-serially,
// then re-keys, writes or reads the selected field.
// Assumes: N_PART <= 4 (two-bit partition field), CRED_W >= CMD_BITS,
// SC_BITS >= SD_BITS, and all fields are powers of two.
module keyvault_ctrl #(
    parameter int N_PART    = 3,
    parameter int CRED_W    = 64,
    parameter int PART_BITS = 384,
    parameter int SCR_BITS  = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sess_en,
    input  logic bit_vld,
    input  logic bit_in,
    output logic bit_out,
    output logic out_act
);
    import keyvault_pkg::*;

    localparam int SD_BITS = PART_BITS - 2 * CRED_W;
    localparam int SD_IW   = $clog2(SD_BITS);
    localparam int PTR_W   = $clog2(SCR_BITS);
    localparam int CNT_W   = $clog2(CRED_W);

    kv_state_e             st_q, st_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [CMD_BITS-1:0]   cmd_q, cmd_d, cmd_nx;
    logic [PTR_W-1:0]      ptr_q, ptr_d, last_ptr, sc_start, sd_start;
    logic [CRED_W-2:0]     stage_q, stage_d;
    logic [CRED_W-1:0]     cred_val;
    logic                  erase, id_we, pw_we, sd_we, sc_we;
    logic                  id_bit, pw_bit, sd_bit, sc_bit, mm_nx;
    logic                  is_scr, is_rekey, sec_ok, cnt_last;
    logic [3:0]            op_n;

    assign cmd_nx   = {bit_in, cmd_q[CMD_BITS-1:1]};
    assign op_n     = cmd_nx[7:4];
    assign sec_ok   = (op_n == OP_REKEY || op_n == OP_SEC_WR || op_n == OP_SEC_RD)
                      && cmd_nx[3:2] == 2'b00 && int'(cmd_nx[1:0]) < N_PART;
    assign sc_start = PTR_W'({cmd_nx[15:8], 3'b000});
    assign sd_start = PTR_W'(SD_IW'({cmd_q[15:8], 3'b000}));
    assign is_scr   = (cmd_q[7:4] == OP_SCR_WR) || (cmd_q[7:4] == OP_SCR_RD);
    assign is_rekey = (cmd_q[7:4] == OP_REKEY);
    assign last_ptr = is_scr ? PTR_W'(SCR_BITS - 1) : PTR_W'(SD_BITS - 1);
    assign cnt_last = (cnt_q == CNT_W'(CRED_W - 1));
    assign cred_val = {bit_in, stage_q};

    // Next-state logic and storage write strobes for each session phase.
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        cmd_d   = cmd_q;
        ptr_d   = ptr_q;
        stage_d = stage_q;
        erase   = 1'b0;
        id_we   = 1'b0;
        pw_we   = 1'b0;
        sd_we   = 1'b0;
        sc_we   = 1'b0;
        if (!sess_en) begin
            st_d  = S_IDLE;
            cnt_d = '0;
        end else if (st_q == S_IDLE) begin
            st_d  = S_CMD;
            cnt_d = '0;
        end else if (bit_vld) begin
            case (st_q)
                S_CMD: begin
                    cmd_d = cmd_nx;
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
                        cnt_d = '0;
                        if (cmd_nx[3:2] == 2'b00 && op_n == OP_SCR_WR) begin
                            st_d = S_WR;  ptr_d = sc_start;
                        end else if (cmd_nx[3:2] == 2'b00 && op_n == OP_SCR_RD) begin
                            st_d = S_RD;  ptr_d = sc_start;
                        end else if (sec_ok) begin
                            st_d = S_IDOUT;
                        end else begin
                            st_d = S_DONE;
                        end
                    end
                end
                S_IDOUT: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_last) begin
                        cnt_d = '0;
                        st_d  = S_CMP;
                    end
                end
                S_CMP: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_last) begin
                        cnt_d = '0;
                        if (mm_nx) begin
                            st_d = S_DONE;
                        end else if (is_rekey) begin
                            erase = 1'b1;
                            st_d  = S_NEWID;
                        end else begin
                            ptr_d = sd_start;
                            st_d  = (cmd_q[7:4] == OP_SEC_WR) ? S_WR : S_RD;
                        end
                    end
                end
                S_NEWID, S_NEWPW: begin
                    stage_d = {bit_in, stage_q[CRED_W-2:1]};
                    cnt_d   = cnt_q + 1'b1;
                    if (cnt_last) begin
                        cnt_d = '0;
                        id_we = (st_q == S_NEWID);
                        pw_we = (st_q == S_NEWPW);
                        st_d  = (st_q == S_NEWID) ? S_NEWPW : S_DONE;
                    end
                end
                S_WR, S_RD: begin
                    sc_we = (st_q == S_WR) && is_scr;
                    sd_we = (st_q == S_WR) && !is_scr;
                    if (ptr_q == last_ptr) st_d = S_DONE;
                    else                   ptr_d = ptr_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Session registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            cnt_q   <= '0;
            cmd_q   <= '0;
            ptr_q   <= '0;
            stage_q <= '0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            cmd_q   <= cmd_d;
            ptr_q   <= ptr_d;
            stage_q <= stage_d;
        end
    end

    keyvault_cmp u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st_q != S_CMP),
        .en      (st_q == S_CMP && bit_vld && sess_en),
        .rx_bit  (bit_in),
        .ref_bit (is_rekey ? id_bit : pw_bit),
        .mm_nx   (mm_nx)
    );

    keyvault_store #(
        .N_PART  (N_PART),
        .CRED_W  (CRED_W),
        .SD_BITS (SD_BITS),
        .SC_BITS (SCR_BITS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .part     (cmd_q[1:0]),
        .fld_idx  (cnt_q),
        .dat_idx  (ptr_q),
        .erase    (erase),
        .id_we    (id_we),
        .pw_we    (pw_we),
        .sd_we    (sd_we),
        .sc_we    (sc_we),
        .wbit     (bit_in),
        .cred_val (cred_val),
        .id_bit   (id_bit),
        .pw_bit   (pw_bit),
        .sd_bit   (sd_bit),
        .sc_bit   (sc_bit)
    );

    assign out_act = (st_q == S_IDOUT) || (st_q == S_RD);
    assign bit_out = (st_q == S_IDOUT) ? id_bit :
                     (st_q == S_RD)    ? (is_scr ? sc_bit : sd_bit) : 1'b0;

    // R8: a dropped session silences the output on the next cycle.
    assert_drop_silences_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sess_en |=> !out_act);

    // R5: a wipe is always followed by the new-identifier phase.
    assert_erase_then_newid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (st_q == S_NEWID));

    // R6: the data pointer never leaves the addressed field.
    assert_ptr_in_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_WR || st_q == S_RD) |-> (ptr_q <= last_ptr));

endmodule

// File: tb/keyvault_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural model of the stored contents and of the expected output
// per slot, compared against the design on every clock.
module keyvault_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n, sess_en, bit_vld, bit_in;
    logic bit_out, out_act;

    always #2.5 clk = ~clk;

    keyvault_ctrl dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sess_en (sess_en),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .bit_out (bit_out),
        .out_act (out_act)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    int    slot_no = 0;
    string cur_req = "R1";
    logic  exp_valid = 1'b0;
    logic  exp_act = 1'b0;
    logic  exp_bit = 1'b0;

    logic [63:0]  m_id [3];
    logic [63:0]  m_pw [3];
    logic [255:0] m_sd [3];
    logic [511:0] m_sc;

    localparam logic [63:0] ID1 = 64'h3C5A_96E1_0F72_B4D8;
    localparam logic [63:0] PW1 = 64'h71E2_D34C_A58B_690F;
    localparam logic [63:0] ID2 = 64'hE01F_5A3C_7B96_22D4;
    localparam logic [63:0] PW2 = 64'h0D9C_B7A2_4E61_F853;
    localparam logic [511:0] PA = {8{64'hA5C3_0F1E_9B72_D468}};
    localparam logic [511:0] PB = {8{64'h5E19_C2B7_34F0_8A6D}};

    task automatic chk(input logic ok, input string req, input logic act, input logic expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, expv);
        end
    endtask

    // Per-clock comparison against the model's expectation.
    always @(negedge clk) begin
        if (rst_n && exp_valid) begin
            chk(out_act === exp_act, cur_req, out_act, exp_act);
            if (exp_act) chk(bit_out === exp_bit, cur_req, bit_out, exp_bit);
        end
    end

    task automatic slot(input logic b, input logic ea, input logic eb);
        slot_no++;
        exp_valid = 1'b1; exp_act = ea; exp_bit = eb;
        if (slot_no % 7 == 0) begin   // R2: idle gap, nothing may advance
            bit_vld = 1'b0;
            @(posedge clk); #1;
        end
        bit_vld = 1'b1; bit_in = b;
        @(posedge clk); #1;
        bit_vld = 1'b0;
    endtask

    task automatic open_s();
        sess_en = 1'b1; bit_vld = 1'b0;
        exp_valid = 1'b1; exp_act = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic close_s();
        sess_en = 1'b0; bit_vld = 1'b0; exp_valid = 1'b0;
        @(posedge clk); #1;
        exp_valid = 1'b1; exp_act = 1'b0;   // R8: silent on the next cycle
        @(posedge clk); #1;
    endtask

    task automatic send_cmd(input int op, input int part, input int addr);
        logic [7:0] cb;
        logic [7:0] ab;
        cb = {op[3:0], 2'b00, part[1:0]};
        ab = addr[7:0];
        for (int i = 0; i < 8; i++) slot(cb[i], 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) slot(ab[i], 1'b0, 1'b0);
    endtask

    task automatic run_op(input int op, input int part, input int addr,
                          input logic [63:0] cred, input logic [511:0] pay,
                          input int n, input string req);
        logic ok;
        int   st;
        cur_req = req;
        open_s();
        send_cmd(op, part, addr);
        if (op == 4 || op == 5) begin
            st = (addr % 64) * 8;
            for (int i = 0; i < n; i++) begin
                if (op == 4) begin
                    slot(pay[i], 1'b0, 1'b0);
                    if (st + i <= 511) m_sc[st + i] = pay[i];
                end else if (st + i <= 511) slot(1'b0, 1'b1, m_sc[st + i]);
                else slot(1'b0, 1'b0, 1'b0);
            end
        end else if (op >= 1 && op <= 3 && part < 3) begin
            for (int i = 0; i < 64; i++) slot(1'b0, 1'b1, m_id[part][i]);
            ok = (op == 1) ? (cred == m_id[part]) : (cred == m_pw[part]);
            for (int i = 0; i < 64; i++) slot(cred[i], 1'b0, 1'b0);
            if (!ok) begin
                for (int i = 0; i < n; i++) slot(pay[i], 1'b0, 1'b0);
            end else if (op == 1) begin
                m_id[part] = '0; m_pw[part] = '0; m_sd[part] = '0;
                for (int i = 0; i < n; i++) slot(pay[i], 1'b0, 1'b0);
                if (n >= 64)  m_id[part] = pay[63:0];
                if (n >= 128) m_pw[part] = pay[127:64];
            end else begin
                st = (addr % 32) * 8;
                for (int i = 0; i < n; i++) begin
                    if (op == 2) begin
                        slot(pay[i], 1'b0, 1'b0);
                        if (st + i <= 255) m_sd[part][st + i] = pay[i];
                    end else if (st + i <= 255) slot(1'b0, 1'b1, m_sd[part][st + i]);
                    else slot(1'b0, 1'b0, 1'b0);
                end
            end
        end else begin
            for (int i = 0; i < n; i++) slot(pay[i], 1'b0, 1'b0);
        end
        close_s();
    endtask

    initial begin
        for (int p = 0; p < 3; p++) begin
            m_id[p] = '0; m_pw[p] = '0; m_sd[p] = '0;
        end
        m_sc = '0;
        rst_n = 1'b0; sess_en = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1 chk(out_act === 1'b0, "R1", out_act, 1'b0);
        exp_valid = 1'b1; exp_act = 1'b0;
        @(posedge clk); #1;

        run_op(3, 0, 0, 64'h0, '0, 256, "R1");          // zeroed after reset
        run_op(4, 0, 66, 64'h0, PA, 40, "R9");          // address wraps to byte 2
        run_op(5, 0, 0, 64'h0, '0, 512, "R9");
        run_op(5, 0, 62, 64'h0, '0, 20, "R9");          // stops after bit 511
        run_op(5, 0, 2, 64'h0, '0, 64, "R2");
        run_op(1, 1, 0, 64'h1, {384'b0, PW1, ID1}, 128, "R4");   // bit 0 wrong
        run_op(3, 1, 0, 64'h0, '0, 16, "R4");           // still old credentials
        run_op(1, 1, 0, 64'h0, {384'b0, PW1, ID1}, 140, "R5");
        run_op(2, 1, 30, PW1, PB, 20, "R6");            // last 4 bits ignored
        run_op(2, 1, 0, PW1 ^ 64'h8000_0000_0000_0000, PA, 50, "R4"); // bit 63 wrong
        run_op(3, 1, 0, PW1, '0, 256, "R7");
        run_op(3, 1, 28, PW1, '0, 40, "R7");
        run_op(3, 1, 0, PW2, '0, 10, "R3");             // identifier still shown
        run_op(2, 0, 5, 64'h0, PB, 10, "R8");           // partial data write kept
        run_op(1, 2, 0, 64'h0, {384'b0, PW2, ID2}, 30, "R8");    // partial id dropped
        run_op(3, 2, 0, 64'h0, '0, 256, "R8");
        run_op(1, 2, 0, 64'h0, {384'b0, PW2, ID2}, 100, "R8");   // partial pw dropped
        run_op(3, 2, 0, 64'h0, '0, 8, "R8");

        // R8: drop the session in the middle of the identifier phase
        cur_req = "R8";
        open_s();
        send_cmd(3, 0, 0);
        for (int i = 0; i < 10; i++) slot(1'b0, 1'b1, m_id[0][i]);
        close_s();

        run_op(7, 0, 0, 64'h0, PA, 40, "R10");
        run_op(3, 3, 0, 64'h0, PA, 200, "R10");
        run_op(2, 3, 0, 64'h0, PA, 200, "R10");
        run_op(5, 0, 0, 64'h0, '0, 512, "R10");
        run_op(1, 1, 0, ID1, {384'b0, PW2, ID2}, 128, "R5");     // second re-key wipes data
        run_op(3, 1, 0, PW2, '0, 256, "R5");
        run_op(3, 0, 0, 64'h0, '0, 256, "R11");
        run_op(3, 2, 0, 64'h0, '0, 256, "R11");
        run_op(5, 0, 0, 64'h0, '0, 512, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule